// File: doc/BRIEF.md
# Shape-Configurable Dual-Port RAM Stack

This block is a small simple-dual-port memory bank with a fixed storage of 1152 bits per bank. A two-bit shape input picks, at run time, how those bits are seen: as many narrow words or as fewer wide ones. One port only writes and is clocked by its own write clock. The other port only reads, has its own read clock, and offers two read styles. In the registered style the output is a register loaded on the read clock. In the flow-through style the output follows the read address with no clock edge.

Several banks are stacked to give a deeper memory. The address bits directly above the word address of the current shape choose the bank. On the write side these bits steer the write enable to exactly one bank. On the read side they drive the multiplexer that picks which bank's output reaches the port. Every word lives in one flat bit array, so a word written in one shape can be read back in another shape as the same bits.

Top module: `cfgram_stack`

## Requirements
- R1: `shape_sel` selects the word shape. 0 gives 64 words of 18 bits with a 6-bit word address. 1 gives 128x9 with 7 bits. 2 gives 256x4 with 8 bits. 3 gives 512x2 with 9 bits. Read data bits at and above the active width are zero.
- R2: A write takes place on a rising `wclk` edge only when `we` is high. While `we` is low, no stored bit changes.
- R3: With `async_rd` low, a rising `rclk` edge with `re` high loads `rdata` with the addressed word. With `re` low, `rdata` holds its value.
- R4: In registered mode, a read and a write to the same word on the same edge return the data held before the write.
- R5: With `async_rd` and `re` both high, `rdata` shows the word at `raddr` in the same cycle, with no clock edge needed.
- R6: With `async_rd` high and `re` low, `rdata` shows the word captured at the last `rclk` edge where `re` was high.
- R7: In shape s of width W, word i of a bank occupies bank bits i*W up to i*W+W-1. All shapes share those bits, so a change of shape reinterprets the stored contents.
- R8: The bank index is the address field starting just above the word address of the current shape (bit 6 plus the shape code), NUM_BANKS wide in log2. A write reaches only that bank. Address bits above that field are ignored.
- R9: The read multiplexer picks the bank from the same field of `raddr`. In registered mode it uses the index sampled at the read edge that loaded the data.
- R10: While `rst_n` is low, the read register and the sampled bank index clear, so `rdata` is zero in registered mode. Stored contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low asynchronous reset of the read registers |
| shape_sel | input | 2 | Word shape code (R1) |
| we | input | 1 | Write enable, sampled on `wclk` |
| waddr | input | 9+log2(NUM_BANKS) | Write address: bank field above the word address |
| wdata | input | 18 | Write data; bits above the active width ignored |
| re | input | 1 | Read enable |
| async_rd | input | 1 | 1 = flow-through read, 0 = registered read |
| raddr | input | 9+log2(NUM_BANKS) | Read address |
| rdata | output | 18 | Read data |

## Verification
On every clock, the assertions check three things: that at most one bank's write enable is raised and none without `we`, that a read edge loads the word that stood at the address just before it (which covers the old-data rule for a colliding write), and that the output stays steady while the read enable is low. Some behaviours only the bench scenarios can show, because they depend on data stored many cycles earlier. These are the bit layout shared across shapes, ignored upper address bits, the zeroed upper data bits, the content kept through reset, and the same-cycle flow-through response. The bench shows them by comparing against a bit-level model on every cycle.

// File: rtl/cfgram_pkg.sv
package cfgram_pkg;

    localparam int BANK_BITS = 1152;
    localparam int DATA_W    = 18;
    localparam int WADDR_W   = 9;
    localparam int MIN_ABITS = 6;
    localparam int BIT_IDX_W = $clog2(BANK_BITS);

    typedef enum logic [1:0] {
        SHAPE_64X18  = 2'b00,
        SHAPE_128X9  = 2'b01,
        SHAPE_256X4  = 2'b10,
        SHAPE_512X2  = 2'b11
    } shape_e;

    function automatic int shape_width(shape_e s);
        int w;
        unique case (s)
            SHAPE_64X18: w = 18;
            SHAPE_128X9: w = 9;
            SHAPE_256X4: w = 4;
            SHAPE_512X2: w = 2;
            default:     w = 18;
        endcase
        return w;
    endfunction

    function automatic int shape_abits(shape_e s);
        return MIN_ABITS + int'(s);
    endfunction

endpackage

// File: rtl/cfgram_addr_split.sv
module cfgram_addr_split
    import cfgram_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  shape_e                     shape,
    input  logic [WADDR_W+SEL_W-1:0]   addr,
    output logic [WADDR_W-1:0]         word,
    output logic [SEL_W-1:0]           bank
);

    int ab;

    always_comb begin
        ab   = shape_abits(shape);
        word = addr[WADDR_W-1:0] & WADDR_W'((32'd1 << ab) - 32'd1);
        bank = SEL_W'(addr >> ab);
    end

endmodule

// File: rtl/cfgram_we_decode.sv
module cfgram_we_decode #(
    parameter int NUM_BANKS = 4,
    localparam int SEL_W    = $clog2(NUM_BANKS)
) (
    input  logic                 wclk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     bank,
    output logic [NUM_BANKS-1:0] we_vec
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
        assign we_vec[b] = we && (bank == SEL_W'(b));
    end

    AST_ONE_BANK_WE: assert property (@(posedge wclk) disable iff (!rst_n)
        $onehot0(we_vec)); // R8

    AST_WE_GATED: assert property (@(posedge wclk) disable iff (!rst_n)
        !we |-> (we_vec == '0)); // R2

endmodule

// File: rtl/cfgram_bank.sv
module cfgram_bank
    import cfgram_pkg::*;
(
    input  logic               wclk,
    input  logic               rclk,
    input  logic               rst_n,
    input  shape_e             shape,
    input  logic               we,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               re,
    input  logic               async_rd,
    input  logic [WADDR_W-1:0] raddr,
    output logic [DATA_W-1:0]  rdata
);

    logic [BANK_BITS-1:0] cells;
    logic [DATA_W-1:0]    look;
    logic [DATA_W-1:0]    rd_q;
    logic [WADDR_W-1:0]   amask;
    int                   width;
    int                   wbase;
    int                   rbase;

    always_comb begin
        width = shape_width(shape);
        amask = WADDR_W'((32'd1 << shape_abits(shape)) - 32'd1);
        wbase = int'(waddr & amask) * width;
        rbase = int'(raddr & amask) * width;
    end

    // Write port: enable acts as clock enable
    always_ff @(posedge wclk) begin
        if (we) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (i < width) begin
                    cells[BIT_IDX_W'(wbase + i)] <= wdata[i];
                end
            end
        end
    end

    // Word lookup, upper bits forced to zero
    always_comb begin
        look = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < width) begin
                look[i] = cells[BIT_IDX_W'(rbase + i)];
            end
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (re) begin
            rd_q <= look;
        end
    end

    assign rdata = (async_rd && re) ? look : rd_q;

    AST_RD_CAPTURE: assert property (@(posedge rclk) disable iff (!rst_n)
        re |=> ((async_rd && re) || (rdata == $past(look)))); // R4

endmodule

// File: rtl/cfgram_stack.sv
module cfgram_stack
    import cfgram_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                                    wclk,
    input  logic                                    rclk,
    input  logic                                    rst_n,
    input  logic [1:0]                              shape_sel,
    input  logic                                    we,
    input  logic [WADDR_W+$clog2(NUM_BANKS)-1:0]    waddr,
    input  logic [DATA_W-1:0]                       wdata,
    input  logic                                    re,
    input  logic                                    async_rd,
    input  logic [WADDR_W+$clog2(NUM_BANKS)-1:0]    raddr,
    output logic [DATA_W-1:0]                       rdata
);

    localparam int SEL_W = $clog2(NUM_BANKS);

    shape_e                shape;
    logic [WADDR_W-1:0]    wword;
    logic [WADDR_W-1:0]    rword;
    logic [SEL_W-1:0]      wbank;
    logic [SEL_W-1:0]      rbank_cur;
    logic [SEL_W-1:0]      rbank_q;
    logic [SEL_W-1:0]      rsel;
    logic [NUM_BANKS-1:0]  we_vec;
    logic [DATA_W-1:0]     bank_rd [NUM_BANKS];

    assign shape = shape_e'(shape_sel);

    cfgram_addr_split #(.SEL_W(SEL_W)) u_wsplit (
        .shape (shape),
        .addr  (waddr),
        .word  (wword),
        .bank  (wbank)
    );

    cfgram_addr_split #(.SEL_W(SEL_W)) u_rsplit (
        .shape (shape),
        .addr  (raddr),
        .word  (rword),
        .bank  (rbank_cur)
    );

    cfgram_we_decode #(.NUM_BANKS(NUM_BANKS)) u_wedec (
        .wclk   (wclk),
        .rst_n  (rst_n),
        .we     (we),
        .bank   (wbank),
        .we_vec (we_vec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        cfgram_bank u_bank (
            .wclk     (wclk),
            .rclk     (rclk),
            .rst_n    (rst_n),
            .shape    (shape),
            .we       (we_vec[b]),
            .waddr    (wword),
            .wdata    (wdata),
            .re       (re),
            .async_rd (async_rd),
            .raddr    (rword),
            .rdata    (bank_rd[b])
        );
    end

    // Bank index that belongs with the registered read data
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbank_q <= '0;
        end else if (re) begin
            rbank_q <= rbank_cur;
        end
    end

    assign rsel  = (async_rd && re) ? rbank_cur : rbank_q;
    assign rdata = bank_rd[rsel];

    AST_RD_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
        !re |=> ((async_rd && re) || $stable(rdata))); // R3

endmodule

// File: tb/tb_cfgram_stack.sv
`timescale 1ns/1ps
module tb_cfgram_stack;

    localparam int NB = 4;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    shape_sel;
    logic          we;
    logic [AW-1:0] waddr;
    logic [17:0]   wdata;
    logic          re;
    logic          async_rd;
    logic [AW-1:0] raddr;
    logic [17:0]   rdata;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    bit          mdl [NB][1152];
    logic [17:0] exp_q;

    always #2.5 clk = ~clk;

    cfgram_stack #(.NUM_BANKS(NB)) dut (
        .wclk (clk), .rclk (clk), .rst_n (rst_n), .shape_sel (shape_sel),
        .we (we), .waddr (waddr), .wdata (wdata),
        .re (re), .async_rd (async_rd), .raddr (raddr), .rdata (rdata)
    );

    function automatic int wid(logic [1:0] sh);
        case (sh)
            2'd0: return 18;
            2'd1: return 9;
            2'd2: return 4;
            default: return 2;
        endcase
    endfunction

    function automatic logic [17:0] m_read(logic [1:0] sh, logic [AW-1:0] a);
        int w  = wid(sh);
        int ab = 6 + int'(sh);
        int wd = int'(a) & ((1 << ab) - 1);
        int bk = (int'(a) >> ab) & (NB - 1);
        logic [17:0] v = '0;
        for (int i = 0; i < w; i++) v[i] = mdl[bk][wd * w + i];
        return v;
    endfunction

    task automatic m_write(logic [1:0] sh, logic [AW-1:0] a, logic [17:0] d);
        int w  = wid(sh);
        int ab = 6 + int'(sh);
        int wd = int'(a) & ((1 << ab) - 1);
        int bk = (int'(a) >> ab) & (NB - 1);
        for (int i = 0; i < w; i++) mdl[bk][wd * w + i] = d[i];
    endtask

    task automatic check(string tag, logic [17:0] got, logic [17:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: rdata=%h expected %h at %0t", tag, got, want, $time);
        end
    endtask

    // One cycle: inputs already applied at the falling edge
    task automatic cyc(input logic w_en, input logic [AW-1:0] wa, input logic [17:0] wd,
                       input logic r_en, input logic fl, input logic [AW-1:0] ra,
                       input string tag);
        logic [17:0] e;
        we = w_en; waddr = wa; wdata = wd;
        re = r_en; async_rd = fl; raddr = ra;
        #1;
        if (fl && r_en) e = m_read(shape_sel, ra);
        else if (!rst_n) e = '0;
        else e = exp_q;
        check(tag, rdata, e);
        @(posedge clk);
        if (!rst_n) exp_q = '0;
        else if (r_en) exp_q = m_read(shape_sel, ra);
        if (w_en) m_write(shape_sel, wa, wd);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        rst_n = 1'b0; shape_sel = 2'd0; exp_q = '0;
        we = 0; waddr = '0; wdata = '0; re = 0; async_rd = 0; raddr = '0;
        @(negedge clk);
        // R10: reset state of the read output
        repeat (3) cyc(0, '0, '0, 0, 0, '0, "R10");
        rst_n = 1'b1;

        // R2: fill every bank in shape 0, bank field at bits [7:6]
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < 64; k++)
                cyc(1, AW'((b << 6) | k), 18'($urandom), 0, 0, '0, "R2");

        // R8: same word index in every bank, distinct data
        for (int b = 0; b < NB; b++)
            cyc(1, AW'((b << 6) | 5), 18'(18'h1000 + b), 0, 0, '0, "R8");
        // R8: upper bits [10:8] ignored
        cyc(1, 11'h700 | 11'h040 | 11'd9, 18'h2abcd, 0, 0, '0, "R8");
        // R9: registered read back across banks
        for (int b = 0; b < NB; b++)
            cyc(0, '0, '0, 1, 0, AW'((b << 6) | 5), "R9");
        cyc(0, '0, '0, 1, 0, 11'h049, "R8");
        cyc(0, '0, '0, 1, 0, 11'h749, "R8");

        // R2: write enable low must not store
        cyc(0, 11'h0c5, 18'h3ffff, 0, 0, '0, "R2");
        cyc(0, '0, '0, 1, 0, 11'h0c5, "R2");
        cyc(0, '0, '0, 0, 0, '0, "R2");

        // R3: hold while re low, address moving
        cyc(0, '0, '0, 1, 0, 11'h013, "R3");
        for (int k = 0; k < 4; k++)
            cyc(0, '0, '0, 0, 0, AW'(k * 37), "R3");

        // R4: same-address collision returns old data, then new
        cyc(1, 11'h085, 18'h15a5a, 1, 0, 11'h085, "R4");
        cyc(0, '0, '0, 1, 0, 11'h085, "R4");
        cyc(0, '0, '0, 0, 0, '0, "R4");

        // R5 / R9: flow-through across banks
        for (int k = 0; k < 8; k++)
            cyc(0, '0, '0, 1, 1, AW'(k * 41 + 3), "R5");
        // R6: flow-through with re low shows last captured word
        for (int k = 0; k < 3; k++)
            cyc(0, '0, '0, 0, 1, AW'(k * 77), "R6");
        // R5: write then flow-through read of the same word
        cyc(1, 11'h0d0, 18'h0beef, 0, 1, '0, "R5");
        cyc(0, '0, '0, 1, 1, 11'h0d0, "R5");

        // R1: the narrower shapes, all-ones data shows zeroed upper bits
        for (int s = 1; s < 4; s++) begin
            shape_sel = 2'(s);
            for (int k = 0; k < 6; k++) begin
                a = AW'(((k % NB) << (6 + s)) | (k * 11));
                cyc(1, a, 18'h3ffff ^ 18'(k), 0, 0, '0, "R1");
            end
            for (int k = 0; k < 6; k++) begin
                a = AW'(((k % NB) << (6 + s)) | (k * 11));
                cyc(0, '0, '0, 1, k[0], a, "R1");
            end
            cyc(0, '0, '0, 0, 0, '0, "R1");
        end

        // R7: write 2-bit words, read back as an 18-bit word
        shape_sel = 2'd3;
        for (int k = 0; k < 9; k++)
            cyc(1, AW'(k), 18'(k + 1), 0, 0, '0, "R7");
        shape_sel = 2'd0;
        cyc(0, '0, '0, 1, 0, '0, "R7");
        cyc(0, '0, '0, 1, 1, '0, "R7");
        shape_sel = 2'd1;
        cyc(0, '0, '0, 1, 0, 11'd1, "R7");
        cyc(0, '0, '0, 0, 0, '0, "R7");

        // R10: reset clears output, keeps contents
        shape_sel = 2'd0;
        cyc(0, '0, '0, 1, 0, 11'h085, "R10");
        rst_n = 1'b0;
        cyc(0, '0, '0, 0, 0, '0, "R10");
        rst_n = 1'b1;
        cyc(0, '0, '0, 0, 0, '0, "R10");
        cyc(0, '0, '0, 1, 0, 11'h085, "R10");
        cyc(0, '0, '0, 0, 0, '0, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule